// File: doc/BRIEF.md
# Receive FIFO Read Index Tracker

This block keeps the consumer-side state of a receive FIFO whose entries are message buffers held in a shared buffer memory. Software sets up the FIFO's window while the controller is in its configuration state. The setup has four values: the header number of the first entry, how many entries the window holds, the payload size of one entry, and how pops are requested. After that, the block shows the header number of the oldest unread entry and the number of entries waiting to be read.

Software removes entries in one of two ways, chosen by a mode bit. In flag mode, writing a one to the not-empty flag register removes exactly one entry. In count mode, software writes a pop count to a dedicated register, and up to that many entries are removed at once. The read pointer moves through header numbers that begin at the configured start index, and it wraps inside the window. A push pulse from the write side adds one entry to the fill level.

Top module: `rxq_read_tracker`

## Requirements
- R1: After a synchronous reset the read index, fill level, depth, entry size and pop mode all read 0.
- R2: Register writes use address 0 for the start index (data bits 7:0), address 1 for the geometry (depth in bits 7:0, entry size in 2-byte units in bits 14:8) and address 2 for the pop mode (bit 0; 0 selects flag mode, 1 selects count mode). These three registers accept writes only while `cfg_active_i` is high. Outside that state the writes are dropped.
- R3: In any cycle with `cfg_active_i` high, at the next edge the read index is loaded with the start index and the fill level with 0, and pushes and pops are ignored. So the first cycle after the configuration state is left begins at the start index with an empty FIFO.
- R4: A push pulse raises the fill level by one at the next edge. The push is dropped when the fill level already equals the depth.
- R5: In flag mode, a write to address 3 with data bit 0 set pops one entry. In count mode, writes to address 3 have no effect.
- R6: In count mode, a write to address 4 pops min(data bits 7:0, fill level) entries. A count of 0 does nothing. In flag mode, writes to address 4 have no effect.
- R7: A pop while the fill level is 0 changes neither the index nor the fill level.
- R8: The read index equals start + offset, modulo 256. Each pop of n entries advances the offset by n modulo the depth, so the index stays within start to start + depth - 1.
- R9: At the edge where a pop is granted, the index moves and the fill level drops by the number of entries popped. An accepted push in the same cycle is added to that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active_i | input | 1 | Controller is in its configuration state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| push_i | input | 1 | One entry stored by the write side |
| rd_idx_o | output | 8 | Header number of the next readable entry |
| fill_o | output | 8 | Entries waiting to be read |
| depth_o | output | 8 | Configured depth |
| entry_size_o | output | 7 | Configured entry payload size (2-byte units) |
| pop_mode_o | output | 1 | Configured pop mode |

## Verification
The assertions check several invariants on every cycle. The fill level never exceeds the depth. The offset stays inside the window. The configuration registers hold still outside the configuration state. Being in the configuration state forces the index back to the start with the FIFO empty, and when nothing is pushed or popped the fill level does not change. Some behaviours depend on stimulus and only the bench's scenarios can show them: the pop size for each mode, the clamping of oversized counts, dropped pushes when the FIFO is full, ignored pops on an empty FIFO, and wrap-around at different depths and start values, including start values near the top of the index range.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        POP_BY_FLAG  = 1'b0,
        POP_BY_COUNT = 1'b1
    } pop_mode_e;

    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_GEOM  = 3'd1,
        SEL_MODE  = 3'd2,
        SEL_FLAG  = 3'd3,
        SEL_COUNT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic flag_hit;
        logic count_hit;
    } pop_req_t;

    function automatic logic sel_is(input logic [2:0] addr, input reg_sel_e sel);
        return addr == 3'(sel);
    endfunction

endpackage

// File: rtl/rxq_cfg_regs.sv
module rxq_cfg_regs
    import rxq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3,
    parameter int IDX_W   = 8,
    parameter int DEPTH_W = 8,
    parameter int SIZE_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_active_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [IDX_W-1:0]   start_q,
    output logic [DEPTH_W-1:0] depth_q,
    output logic [SIZE_W-1:0]  size_q,
    output pop_mode_e          mode_q
);
    localparam int SIZE_LSB = DEPTH_W;

    logic cfg_wr;
    assign cfg_wr = wr_en_i && cfg_active_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            depth_q <= '0;
            size_q  <= '0;
            mode_q  <= POP_BY_FLAG;
        end else if (cfg_wr) begin
            if (sel_is(3'(wr_addr_i), SEL_START))
                start_q <= wr_data_i[IDX_W-1:0];
            if (sel_is(3'(wr_addr_i), SEL_GEOM)) begin
                depth_q <= wr_data_i[DEPTH_W-1:0];
                size_q  <= wr_data_i[SIZE_LSB +: SIZE_W];
            end
            if (sel_is(3'(wr_addr_i), SEL_MODE))
                mode_q <= pop_mode_e'(wr_data_i[0]);
        end
    end

    // R2
    geom_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_active_i |=> ($stable(depth_q) && $stable(size_q) && $stable(start_q) && $stable(mode_q)));

endmodule

// File: rtl/rxq_pop_ctrl.sv
module rxq_pop_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3,
    parameter int DEPTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_active_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               push_i,
    input  pop_mode_e          mode_i,
    input  logic [DEPTH_W-1:0] depth_i,
    output logic [DEPTH_W-1:0] fill_q,
    output logic [DEPTH_W-1:0] grant_o
);
    pop_req_t             req;
    logic [DEPTH_W-1:0]   want;
    logic                 push_ok;
    logic [DEPTH_W-1:0]   fill_d;

    always_comb begin
        req.flag_hit  = wr_en_i && !cfg_active_i && (mode_i == POP_BY_FLAG)
                        && sel_is(3'(wr_addr_i), SEL_FLAG) && wr_data_i[0];
        req.count_hit = wr_en_i && !cfg_active_i && (mode_i == POP_BY_COUNT)
                        && sel_is(3'(wr_addr_i), SEL_COUNT);
        if (req.flag_hit)
            want = DEPTH_W'(1);
        else if (req.count_hit)
            want = wr_data_i[DEPTH_W-1:0];
        else
            want = '0;
        grant_o = (want > fill_q) ? fill_q : want;
        push_ok = push_i && !cfg_active_i && (fill_q < depth_i);
        fill_d  = fill_q - grant_o + DEPTH_W'(push_ok);
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_active_i)
            fill_q <= '0;
        else
            fill_q <= fill_d;
    end

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_q <= depth_i);

    // R7
    idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_active_i && !push_i && !(wr_en_i && (sel_is(3'(wr_addr_i), SEL_FLAG)
            || sel_is(3'(wr_addr_i), SEL_COUNT)))) |=> $stable(fill_q));

endmodule

// File: rtl/rxq_index_walk.sv
module rxq_index_walk #(
    parameter int IDX_W   = 8,
    parameter int DEPTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_active_i,
    input  logic [IDX_W-1:0]   start_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [DEPTH_W-1:0] grant_i,
    output logic [IDX_W-1:0]   rd_idx_o
);
    localparam int SUM_W = DEPTH_W + 1;

    logic [DEPTH_W-1:0] off_q;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   wrapped;

    always_comb begin
        sum = {1'b0, off_q} + {1'b0, grant_i};
        if (sum >= {1'b0, depth_i})
            wrapped = sum - {1'b0, depth_i};
        else
            wrapped = sum;
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_active_i)
            off_q <= '0;
        else if (grant_i != '0)
            off_q <= wrapped[DEPTH_W-1:0];
    end

    assign rd_idx_o = start_i + IDX_W'(off_q);

    // R8
    off_window_chk: assert property (@(posedge clk) disable iff (rst)
        (depth_i != '0) |-> (off_q < depth_i));

    // R3
    cfg_reload_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_active_i |=> (rd_idx_o == start_i));

endmodule

// File: rtl/rxq_read_tracker.sv
module rxq_read_tracker
    import rxq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3,
    parameter int IDX_W   = 8,
    parameter int DEPTH_W = 8,
    parameter int SIZE_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_active_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               push_i,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic [DEPTH_W-1:0] fill_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic [SIZE_W-1:0]  entry_size_o,
    output logic               pop_mode_o
);
    logic [IDX_W-1:0]   start_w;
    logic [DEPTH_W-1:0] depth_w;
    logic [DEPTH_W-1:0] grant_w;
    pop_mode_e          mode_w;

    rxq_cfg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .DEPTH_W(DEPTH_W), .SIZE_W(SIZE_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_active_i(cfg_active_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .start_q(start_w), .depth_q(depth_w), .size_q(entry_size_o), .mode_q(mode_w)
    );

    rxq_pop_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)
    ) u_pop (
        .clk(clk), .rst(rst), .cfg_active_i(cfg_active_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .push_i(push_i), .mode_i(mode_w), .depth_i(depth_w),
        .fill_q(fill_o), .grant_o(grant_w)
    );

    rxq_index_walk #(
        .IDX_W(IDX_W), .DEPTH_W(DEPTH_W)
    ) u_idx (
        .clk(clk), .rst(rst), .cfg_active_i(cfg_active_i),
        .start_i(start_w), .depth_i(depth_w), .grant_i(grant_w),
        .rd_idx_o(rd_idx_o)
    );

    assign depth_o    = depth_w;
    assign pop_mode_o = mode_w;

    // R9
    move_with_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_active_i && !push_i && grant_w != '0) |=> (fill_o == $past(fill_o) - $past(grant_w)));

endmodule

// File: tb/sim_rxq_read_tracker.sv
module sim_rxq_read_tracker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] data = '0;
    logic        push = 1'b0;
    logic [7:0]  rd_idx, fill, depth;
    logic [6:0]  esize;
    logic        pmode;

    rxq_read_tracker u0 (
        .clk(clk), .rst(rst), .cfg_active_i(cfg), .wr_en_i(we), .wr_addr_i(addr),
        .wr_data_i(data), .push_i(push), .rd_idx_o(rd_idx), .fill_o(fill),
        .depth_o(depth), .entry_size_o(esize), .pop_mode_o(pmode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string tag = "R1";

    // bench model of the expected state after the next edge
    int m_start = 0, m_depth = 0, m_size = 0, m_mode = 0, m_off = 0, m_fill = 0;

    function automatic int exp_idx();
        return (m_start + m_off) % 256;
    endfunction

    task automatic chk(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
        end
    endtask

    task automatic compare();
        chk("rd_idx", int'(rd_idx), exp_idx());
        chk("fill", int'(fill), m_fill);
        chk("depth", int'(depth), m_depth);
        chk("entry_size", int'(esize), m_size);
        chk("pop_mode", int'(pmode), m_mode);
    endtask

    function automatic void model(bit c, bit w, int a, int d, bit p);
        int want, grant, pk;
        if (c) begin
            if (w && a == 0) m_start = d & 8'hFF;
            if (w && a == 1) begin m_depth = d & 8'hFF; m_size = (d >> 8) & 7'h7F; end
            if (w && a == 2) m_mode = d & 1;
            m_off = 0;
            m_fill = 0;
        end else begin
            want = 0;
            if (w && a == 3 && m_mode == 0 && (d & 1) != 0) want = 1;
            if (w && a == 4 && m_mode == 1) want = d & 8'hFF;
            grant = (want > m_fill) ? m_fill : want;
            pk = (p && m_fill < m_depth) ? 1 : 0;
            m_fill = m_fill - grant + pk;
            if (m_depth != 0) m_off = (m_off + grant) % m_depth;
        end
    endfunction

    // called at a falling edge: check last result, drive new inputs, advance model
    task automatic step(string t, bit c, bit w, int a, int d, bit p);
        compare();
        tag = t;
        cfg = c; we = w; addr = 3'(a); data = 16'(d); push = p;
        model(c, w, a, d, p);
        @(negedge clk);
    endtask

    task automatic configure(int st, int dp, int sz, int md);
        step("R2", 1'b1, 1'b1, 0, st, 1'b0);
        step("R2", 1'b1, 1'b1, 1, (sz << 8) | dp, 1'b0);
        step("R2", 1'b1, 1'b1, 2, md, 1'b0);
        step("R3", 1'b0, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic rand_run(string t, int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom_range(0, 9);
            bit p = ($urandom_range(0, 2) != 0);
            if (r < 3)
                step(t, 1'b0, 1'b1, 3, $urandom_range(0, 3), p);
            else if (r < 6)
                step(t, 1'b0, 1'b1, 4, $urandom_range(0, 12), p);
            else
                step(t, 1'b0, 1'b0, 0, 0, p);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        tag = "R1";
        step("R1", 1'b0, 1'b0, 0, 0, 1'b0);
        // R2 configuration, start near top of index range
        configure(250, 5, 12, 0);
        step("R2", 1'b0, 1'b1, 1, (3 << 8) | 9, 1'b0);
        step("R2", 1'b0, 1'b1, 2, 1, 1'b0);
        step("R2", 1'b0, 1'b1, 0, 7, 1'b0);
        // R7 pop on empty
        step("R7", 1'b0, 1'b1, 3, 1, 1'b0);
        step("R7", 1'b0, 1'b0, 0, 0, 1'b0);
        // R4 fill up to depth and beyond
        for (int i = 0; i < 7; i++) step("R4", 1'b0, 1'b0, 0, 0, 1'b1);
        // R5 flag pops; count register ignored in flag mode (R6)
        step("R5", 1'b0, 1'b1, 3, 1, 1'b0);
        step("R6", 1'b0, 1'b1, 4, 3, 1'b0);
        step("R5", 1'b0, 1'b1, 3, 0, 1'b0);
        step("R5", 1'b0, 1'b1, 3, 1, 1'b0);
        // R9 pop and push in same cycle
        step("R9", 1'b0, 1'b1, 3, 1, 1'b1);
        // R8 wrap across start+depth-1 and index modulo 256
        rand_run("R8", 300);
        // R3 reconfigure: index back to start, fill cleared
        step("R3", 1'b0, 1'b0, 0, 0, 1'b1);
        configure(10, 7, 20, 1);
        step("R3", 1'b1, 1'b0, 0, 0, 1'b1);
        step("R3", 1'b0, 1'b0, 0, 0, 1'b0);
        // R6 count mode: flag ignored (R5), clamp, zero count
        for (int i = 0; i < 6; i++) step("R4", 1'b0, 1'b0, 0, 0, 1'b1);
        step("R5", 1'b0, 1'b1, 3, 1, 1'b0);
        step("R6", 1'b0, 1'b1, 4, 0, 1'b0);
        step("R6", 1'b0, 1'b1, 4, 4, 1'b0);
        step("R6", 1'b0, 1'b1, 4, 200, 1'b0);
        step("R7", 1'b0, 1'b1, 4, 3, 1'b0);
        rand_run("R6", 400);
        // depth 0: pushes dropped, pops ignored
        configure(33, 0, 1, 1);
        step("R4", 1'b0, 1'b0, 0, 0, 1'b1);
        step("R7", 1'b0, 1'b1, 4, 5, 1'b1);
        // random configurations
        for (int k = 0; k < 20; k++) begin
            configure($urandom_range(0, 255), $urandom_range(1, 12),
                      $urandom_range(0, 127), $urandom_range(0, 1));
            rand_run("R9", 200);
        end
        compare();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule